// File: doc/BRIEF.md
# Crossing-Indexed Hit Buffer with Triggered Lookback

This block keeps detector hit words sorted by the beam crossing that produced them. Every hit arrives with a crossing tag. Its word goes into one of `NUM_BKT` buckets, and the low bits of the tag select the bucket. Each bucket also remembers the full tag of the crossing it currently holds. The first hit of a newer crossing that maps to a bucket throws away the old contents, so the ring always covers the most recent `NUM_BKT` crossings.

A one-cycle trigger strobe asks for the hits of the crossing that lies `LOOKBACK` crossings before the current crossing count (default 42). Triggers wait in a four-entry queue. They are served in order. The bucket's words leave on a valid/ready word stream in the order they were written. A one-cycle `done` pulse closes each readout, including one that found no words. When the sink keeps `out_ready` high, the readout delivers one word per clock.

Each bucket can hold up to `BKT_DEPTH` words of `WORD_W` bits. The default depth is 32 so that the default build stays small, and the buffer is also meant to be built with a depth of 128. Hits beyond a bucket's capacity are dropped, and that bucket's sticky overflow bit is set.

Top module: `xing_hit_ring`

## Requirements
- R1: After reset, `out_valid`, `done` and every bit of `ovf_flags` are 0.
- R2: A hit is stored in bucket `hit_xing mod NUM_BKT`. A readout returns that bucket's words in the order they were written.
- R3: A trigger seen with `cur_xing = C` reads crossing `(C - LOOKBACK) mod 2^XW`, from bucket `(C - LOOKBACK) mod NUM_BKT`. Both results wrap below zero.
- R4: A hit whose tag differs from the tag the bucket holds restarts the bucket with only that hit. A readout of a bucket whose held tag is not the requested crossing returns no words.
- R5: A hit to a bucket that already holds `BKT_DEPTH` words is dropped, and bit `b` of `ovf_flags` is set for that bucket `b`. The bit stays set until a newer crossing restarts the bucket.
- R6: A readout that finds no words still produces exactly one `done` pulse and no output words.
- R7: `done` is high for exactly one cycle per trigger. It comes after the readout's last word has been accepted, and never while `out_valid` is high.
- R8: Up to four triggers wait while another readout drains. They are served in arrival order.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_word` is unchanged on the next cycle.
- R10: With `out_ready` held high, a readout's words leave on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_xing | input | XW | Current crossing count |
| hit_valid | input | 1 | Hit word present this cycle |
| hit_xing | input | XW | Crossing tag of the hit |
| hit_word | input | WORD_W | Hit data |
| trig | input | 1 | One-cycle readout request |
| out_valid | output | 1 | Output word valid |
| out_word | output | WORD_W | Output word |
| out_ready | input | 1 | Sink accepts the word |
| done | output | 1 | One-cycle end-of-readout pulse |
| ovf_flags | output | NUM_BKT | Sticky per-bucket overflow bits |

## Verification
The bound checker examines the handshake and the `done` pulse on every cycle:
- the reset state;
- the word held steady under backpressure;
- `done` is a single cycle and never overlaps a valid word;
- an overflow bit rises only right after a hit.

Only the bench's scenarios can show the following behaviours:
- which crossing a trigger picks, including wrap below zero;
- that reused buckets drop their old contents;
- that queued triggers keep their order;
- that word order matches write order;
- that a drain with the sink always ready has no gaps.

// File: rtl/xhr_pkg.sv
package xhr_pkg;
  typedef enum logic {DR_IDLE, DR_ACTIVE} drain_state_e;
endpackage

// File: rtl/xhr_fifo.sv
module xhr_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp];
  assign count   = cnt;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/xhr_bucket_store.sv
module xhr_bucket_store #(
  parameter int NUM_BKT   = 64,
  parameter int BKT_DEPTH = 32,
  parameter int WORD_W    = 24,
  parameter int XW        = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [XW-1:0]                     wr_xing,
  input  logic [WORD_W-1:0]                 wr_word,
  input  logic                              rd_en,
  input  logic [$clog2(NUM_BKT)-1:0]        rd_bkt,
  input  logic [$clog2(BKT_DEPTH)-1:0]      rd_slot,
  output logic [WORD_W-1:0]                 rd_data,
  input  logic [XW-1:0]                     q_xing,
  output logic [$clog2(BKT_DEPTH+1)-1:0]    q_len,
  output logic [NUM_BKT-1:0]                ovf_flags
);
  localparam int BW = $clog2(NUM_BKT);
  localparam int SW = $clog2(BKT_DEPTH);
  localparam int CW = $clog2(BKT_DEPTH+1);

  logic [WORD_W-1:0] mem [NUM_BKT*BKT_DEPTH];
  logic [XW-1:0]     tag [NUM_BKT];
  logic [CW-1:0]     cnt [NUM_BKT];
  logic [NUM_BKT-1:0] ovf;

  logic [BW-1:0] wbkt, qbkt;
  logic          restart, at_cap, mem_we;
  logic [SW-1:0] wslot;

  assign wbkt    = wr_xing[BW-1:0];
  assign restart = (tag[wbkt] != wr_xing);
  assign at_cap  = (cnt[wbkt] == CW'(BKT_DEPTH));
  assign mem_we  = wr_en && (restart || !at_cap);
  assign wslot   = restart ? '0 : cnt[wbkt][SW-1:0];

  assign qbkt  = q_xing[BW-1:0];
  assign q_len = (tag[qbkt] == q_xing) ? cnt[qbkt] : '0;
  assign ovf_flags = ovf;

  // plain dual-port array: one write, one registered read
  always_ff @(posedge clk) begin
    if (mem_we) mem[{wbkt, wslot}] <= wr_word;
    if (rd_en)  rd_data <= mem[{rd_bkt, rd_slot}];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_BKT; i++) begin
        tag[i] <= '0;
        cnt[i] <= '0;
      end
      ovf <= '0;
    end else if (wr_en) begin
      if (restart) begin
        tag[wbkt] <= wr_xing;
        cnt[wbkt] <= CW'(1);
        ovf[wbkt] <= 1'b0;
      end else if (at_cap) begin
        ovf[wbkt] <= 1'b1;
      end else begin
        cnt[wbkt] <= cnt[wbkt] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/xhr_drain.sv
module xhr_drain
  import xhr_pkg::*;
#(
  parameter int NUM_BKT   = 64,
  parameter int BKT_DEPTH = 32,
  parameter int WORD_W    = 24
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            tq_empty,
  input  logic [$clog2(NUM_BKT)-1:0]      tq_bkt,
  input  logic [$clog2(BKT_DEPTH+1)-1:0]  tq_len,
  output logic                            tq_pop,
  output logic                            rd_en,
  output logic [$clog2(NUM_BKT)-1:0]      rd_bkt,
  output logic [$clog2(BKT_DEPTH)-1:0]    rd_slot,
  input  logic [WORD_W-1:0]               rd_data,
  output logic                            out_valid,
  output logic [WORD_W-1:0]               out_word,
  input  logic                            out_ready,
  output logic                            done
);
  localparam int BW = $clog2(NUM_BKT);
  localparam int SW = $clog2(BKT_DEPTH);
  localparam int CW = $clog2(BKT_DEPTH+1);

  drain_state_e  state;
  logic [BW-1:0] bkt_q;
  logic [SW-1:0] slot_q;
  logic [CW-1:0] remain;
  logic          rd_pend;
  logic          of_empty, of_full, of_pop;
  logic [1:0]    of_count;
  logic [2:0]    occ;
  logic          room;

  assign of_pop = out_valid && out_ready;
  assign occ    = {1'b0, of_count} + {2'b00, rd_pend};
  assign room   = (occ < 3'd2) || (of_pop && occ == 3'd2);
  assign rd_en  = (state == DR_ACTIVE) && (remain != '0) && room;
  assign rd_bkt = bkt_q;
  assign rd_slot = slot_q;
  assign tq_pop = (state == DR_IDLE) && !tq_empty;
  assign out_valid = !of_empty;

  xhr_fifo #(.W(WORD_W), .DEPTH(2)) u_ofifo (
    .clk   (clk),
    .rst   (rst),
    .push  (rd_pend),
    .din   (rd_data),
    .pop   (of_pop),
    .dout  (out_word),
    .empty (of_empty),
    .full  (of_full),
    .count (of_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= DR_IDLE;
      bkt_q   <= '0;
      slot_q  <= '0;
      remain  <= '0;
      rd_pend <= 1'b0;
      done    <= 1'b0;
    end else begin
      rd_pend <= rd_en;
      done    <= 1'b0;
      case (state)
        DR_IDLE: begin
          if (!tq_empty) begin
            bkt_q  <= tq_bkt;
            slot_q <= '0;
            remain <= tq_len;
            state  <= DR_ACTIVE;
          end
        end
        default: begin
          if (rd_en) begin
            slot_q <= slot_q + 1'b1;
            remain <= remain - 1'b1;
          end
          if (remain == '0 && !rd_pend && of_empty) begin
            done  <= 1'b1;
            state <= DR_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/xing_hit_ring.sv
module xing_hit_ring #(
  parameter int NUM_BKT   = 64,
  parameter int BKT_DEPTH = 32,
  parameter int WORD_W    = 24,
  parameter int XW        = 8,
  parameter int LOOKBACK  = 42,
  parameter int TQ_DEPTH  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [XW-1:0]      cur_xing,
  input  logic               hit_valid,
  input  logic [XW-1:0]      hit_xing,
  input  logic [WORD_W-1:0]  hit_word,
  input  logic               trig,
  output logic               out_valid,
  output logic [WORD_W-1:0]  out_word,
  input  logic               out_ready,
  output logic               done,
  output logic [NUM_BKT-1:0] ovf_flags
);
  localparam int BW  = $clog2(NUM_BKT);
  localparam int SW  = $clog2(BKT_DEPTH);
  localparam int CW  = $clog2(BKT_DEPTH+1);
  localparam int TCW = $clog2(TQ_DEPTH+1);
  localparam logic [XW-1:0] LB = XW'(LOOKBACK);

  logic [XW-1:0]     target, tq_head;
  logic              tq_empty, tq_full, tq_pop;
  logic [TCW-1:0]    tq_count;
  logic [CW-1:0]     q_len;
  logic              rd_en;
  logic [BW-1:0]     rd_bkt;
  logic [SW-1:0]     rd_slot;
  logic [WORD_W-1:0] rd_data;

  assign target = cur_xing - LB;

  xhr_fifo #(.W(XW), .DEPTH(TQ_DEPTH)) u_trigq (
    .clk   (clk),
    .rst   (rst),
    .push  (trig),
    .din   (target),
    .pop   (tq_pop),
    .dout  (tq_head),
    .empty (tq_empty),
    .full  (tq_full),
    .count (tq_count)
  );

  xhr_bucket_store #(
    .NUM_BKT(NUM_BKT), .BKT_DEPTH(BKT_DEPTH), .WORD_W(WORD_W), .XW(XW)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (hit_valid),
    .wr_xing   (hit_xing),
    .wr_word   (hit_word),
    .rd_en     (rd_en),
    .rd_bkt    (rd_bkt),
    .rd_slot   (rd_slot),
    .rd_data   (rd_data),
    .q_xing    (tq_head),
    .q_len     (q_len),
    .ovf_flags (ovf_flags)
  );

  xhr_drain #(
    .NUM_BKT(NUM_BKT), .BKT_DEPTH(BKT_DEPTH), .WORD_W(WORD_W)
  ) u_drain (
    .clk       (clk),
    .rst       (rst),
    .tq_empty  (tq_empty),
    .tq_bkt    (tq_head[BW-1:0]),
    .tq_len    (q_len),
    .tq_pop    (tq_pop),
    .rd_en     (rd_en),
    .rd_bkt    (rd_bkt),
    .rd_slot   (rd_slot),
    .rd_data   (rd_data),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_ready (out_ready),
    .done      (done)
  );
endmodule

// File: rtl/xhr_checker.sv
module xhr_checker #(
  parameter int NUM_BKT = 64,
  parameter int WORD_W  = 24
) (
  input logic               clk,
  input logic               rst,
  input logic               hit_valid,
  input logic               out_valid,
  input logic [WORD_W-1:0]  out_word,
  input logic               out_ready,
  input logic               done,
  input logic [NUM_BKT-1:0] ovf_flags
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!out_valid && !done && ovf_flags == '0));

  a_r9_hold_under_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_done_not_with_word: assert property (@(posedge clk) disable iff (rst)
    done |-> !out_valid);

  a_r5_ovf_needs_hit: assert property (@(posedge clk) disable iff (rst)
    ((ovf_flags & ~$past(ovf_flags)) != '0) |-> $past(hit_valid));
endmodule

bind xing_hit_ring xhr_checker #(.NUM_BKT(NUM_BKT), .WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .hit_valid (hit_valid),
  .out_valid (out_valid),
  .out_word  (out_word),
  .out_ready (out_ready),
  .done      (done),
  .ovf_flags (ovf_flags)
);

// File: tb/xing_hit_ring_tb.sv
`timescale 1ns/1ps
module xing_hit_ring_tb;
  localparam int NB = 64, DEP = 8, WW = 24, XW = 8, LBK = 42;

  logic clk = 0, rst = 1;
  logic [XW-1:0] cur_xing = 0, hit_xing = 0;
  logic hit_valid = 0, trig = 0, out_ready = 0;
  logic [WW-1:0] hit_word = 0;
  logic out_valid, done;
  logic [WW-1:0] out_word;
  logic [NB-1:0] ovf_flags;

  always #2 clk = ~clk;

  xing_hit_ring #(.NUM_BKT(NB), .BKT_DEPTH(DEP), .WORD_W(WW), .XW(XW),
                  .LOOKBACK(LBK), .TQ_DEPTH(4)) u_dut (
    .clk(clk), .rst(rst), .cur_xing(cur_xing), .hit_valid(hit_valid),
    .hit_xing(hit_xing), .hit_word(hit_word), .trig(trig),
    .out_valid(out_valid), .out_word(out_word), .out_ready(out_ready),
    .done(done), .ovf_flags(ovf_flags));

  int checks = 0, fails = 0;
  // reference model
  logic [XW-1:0] bm_tag [NB];
  logic [WW-1:0] bm_q [NB][$];
  logic [NB-1:0] bm_ovf;
  logic [WW-1:0] exp_words [$];
  int exp_len [$];
  int outstanding = 0, got_len = 0, last_len = -1, cyc = 0;
  int first_c = -1, last_c = -1;
  bit ready_all = 1, prev_stall = 0;
  logic [WW-1:0] prev_word;

  task automatic check_eq(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      for (int i = 0; i < NB; i++) begin bm_tag[i] = 0; bm_q[i] = {}; end
      bm_ovf = '0;
    end else begin
      if (trig) begin
        logic [XW-1:0] t;
        int b;
        t = cur_xing - XW'(LBK);
        b = int'(t) % NB;
        if (bm_tag[b] == t) begin
          foreach (bm_q[b][k]) exp_words.push_back(bm_q[b][k]);
          exp_len.push_back(bm_q[b].size());
        end else exp_len.push_back(0);
        outstanding++;
      end
      if (hit_valid) begin
        int b;
        b = int'(hit_xing) % NB;
        if (bm_tag[b] != hit_xing) begin
          bm_tag[b] = hit_xing; bm_q[b] = {hit_word}; bm_ovf[b] = 1'b0;
        end else if (bm_q[b].size() == DEP) bm_ovf[b] = 1'b1;
        else bm_q[b].push_back(hit_word);
      end
    end
  end

  // monitor, samples after the drivers settle at the falling edge
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      check_eq("R5 overflow flags", ovf_flags, bm_ovf);
      if (prev_stall) begin
        check_eq("R9 valid held", out_valid, 1);
        check_eq("R9 word held", out_word, prev_word);
      end
      prev_stall = out_valid && !out_ready;
      prev_word  = out_word;
      if (out_valid && !out_ready && first_c >= 0) ready_all = 0;
      if (out_valid && out_ready) begin
        if (first_c < 0) first_c = cyc;
        last_c = cyc;
        got_len++;
        if (exp_words.size() == 0) check_eq("R2 unexpected word", out_word, 0);
        else check_eq("R2 R3 word order", out_word, exp_words.pop_front());
      end
      if (done) begin
        check_eq("R7 done without word", out_valid, 0);
        if (exp_len.size() == 0) check_eq("R7 extra done", 1, 0);
        else check_eq("R8 R6 readout length", got_len, exp_len.pop_front());
        if (ready_all && got_len > 0)
          check_eq("R10 back-to-back words", last_c - first_c + 1, got_len);
        last_len = got_len; got_len = 0; outstanding--;
        first_c = -1; ready_all = 1;
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic put_hits(int x, int n);
    for (int k = 0; k < n; k++) begin
      tick();
      hit_valid = 1; hit_xing = XW'(x);
      hit_word = {8'(x), 8'(k), 8'(8'hA5 ^ 8'(x))};
    end
    tick(); hit_valid = 0;
  endtask

  task automatic fire(int c);
    tick(); cur_xing = XW'(c); trig = 1;
    tick(); trig = 0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while ((outstanding != 0 || exp_words.size() != 0) && guard < 5000) begin
      tick(); guard++;
    end
    check_eq("R7 all readouts completed", outstanding, 0);
  endtask

  function automatic int nhits(int x);
    if (x == 3 || x == 7) return 11;
    return x % 5;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    tick(); #1;
    check_eq("R1 out_valid after reset", out_valid, 0);
    check_eq("R1 done after reset", done, 0);
    check_eq("R1 ovf after reset", ovf_flags, 0);

    // fill crossings 0..41, sink ready
    out_ready = 1;
    for (int x = 0; x < 42; x++) begin cur_xing = XW'(x); put_hits(x, nhits(x)); end
    check_eq("R5 bucket 3 overflow set", ovf_flags[3], 1);

    // queued triggers under a stalled sink, then a toggling sink
    out_ready = 0;
    for (int x = 42; x < 46; x++) begin fire(x); put_hits(x, nhits(x)); end
    for (int i = 0; i < 400 && outstanding != 0; i++) begin
      tick(); out_ready = i[1] ^ i[0];
    end
    out_ready = 1;
    wait_idle();

    // triggers with the sink always ready: buckets 4..7
    for (int x = 46; x < 50; x++) begin fire(x); put_hits(x, nhits(x)); end
    wait_idle();
    check_eq("R2 bucket 7 capped length", last_len, DEP);

    // reuse: crossing 65 replaces bucket 1
    put_hits(65, 2);
    fire(65 + LBK); wait_idle();
    check_eq("R4 reused bucket length", last_len, 2);
    // stale: bucket 2 still holds crossing 2, request is 66
    fire(66 + LBK); wait_idle();
    check_eq("R4 stale bucket gives nothing", last_len, 0);
    check_eq("R6 empty readout done seen", outstanding, 0);
    // overflow cleared by restart of bucket 3
    put_hits(67, 1); tick(); #1;
    check_eq("R5 bucket 3 overflow cleared", ovf_flags[3], 0);

    // wrap below zero: cur 20 -> crossing 234, bucket 42
    put_hits(234, 3);
    fire(20); wait_idle();
    check_eq("R3 wrapped lookback length", last_len, 3);

    repeat (5) tick();
    finish_run();
  end
endmodule